// File: doc/BRIEF.md
# Page Buffer Load and Write Timer

This block gathers byte loads for a page-organised nonvolatile store into a page buffer, and its two inactivity timers decide when loading is over. Each load carries an address and a data byte, and a separate permission input from an upstream protection decoder gates it. The low address bits pick a slot in the page. The upper bits name the page. Loads that arrive close enough together keep the buffer open. A long enough silence closes it and starts a fixed-length programming cycle. At the end of that cycle the whole page is handed to the array in one commit: the page address, every byte, and a per-byte flag that shows which slots the host loaded. Slots the host never loaded are handed over as all ones.

While the programming cycle runs, the block is busy and ignores new loads. Reads during that time return only status. The top bit is the complement of the top bit of the last loaded byte, and the next bit inverts on every read. Once the block is idle again, a read returns the last loaded byte itself. Both timers advance only on cycles where the timing tick input is high, so their lengths are parameters counted in ticks.

Top module: `page_load_ctrl`

## Requirements
- R1: The low log2(PAGE_BYTES) address bits (7 bits by default) select the slot within the page, and the remaining upper bits are reported as `commit_page`.
- R2: While idle, a load with `ld_permit` high is stored and opens loading. During loading, a load that arrives fewer than BLC_CYC ticks after the previous accepted load is stored and restarts the inactivity count.
- R3: During loading, a load that arrives once BLC_CYC or more ticks have passed since the last accepted load is discarded and does not restart the inactivity count.
- R4: With tick high on every cycle, `busy` rises exactly TMO_CYC cycles after the clock edge that captured the last accepted load.
- R5: Loading a slot that is already loaded replaces its buffered byte.
- R6: `commit_page` is the page of the last accepted load, even when earlier loads named a different page.
- R7: At commit, each slot that was not loaded shows 8'hFF in `commit_data` and 0 in `commit_mask`. Each loaded slot shows its byte and 1.
- R8: `commit_valid` is high for exactly one cycle, the PROG_CYC-th ticked cycle of `busy`, and `busy` falls on the next cycle. Loads presented while busy are discarded.
- R9: A read while busy returns, one cycle later, bit 7 equal to the complement of bit 7 of the last accepted byte.
- R10: Bit 6 of consecutive reads while busy alternates. A read while idle returns the last accepted byte unchanged.
- R11: All slot flags are clear after every commit, so the next page starts empty.
- R12: A load with `ld_permit` low is discarded.
- R13: Both timers hold their count on cycles where `tmr_tick` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_tick | input | 1 | Timing tick; timers advance when high |
| ld_en | input | 1 | Byte-load event this cycle |
| ld_addr | input | ADDR_W | Load address: page in upper bits, slot in low bits |
| ld_data | input | DATA_W | Load data byte |
| ld_permit | input | 1 | Load allowed by the protection decoder |
| rd_en | input | 1 | Status/data read request |
| rd_data | output | DATA_W | Read result, valid the cycle after `rd_en` |
| busy | output | 1 | Programming cycle in progress |
| commit_valid | output | 1 | One-cycle commit strobe |
| commit_page | output | ADDR_W-log2(PAGE_BYTES) | Page being committed |
| commit_data | output | PAGE_BYTES*DATA_W | All slots, slot k at bits k*DATA_W upward |
| commit_mask | output | PAGE_BYTES | Per-slot loaded flags |

## Verification
A load takes effect at the clock edge that samples `ld_en`. `busy` follows TMO_CYC edges after that capture, `commit_valid` appears TMO_CYC+PROG_CYC-1 edges after it, and `rd_data` is due one edge after `rd_en`. The bench drives and samples on falling edges. It counts those edges from each capture and checks the cycle just before each due point and the due point itself, so an off-by-one in either timer is caught. Discarded loads are checked afterwards through `commit_mask`, `commit_data` and an idle read.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } pgw_state_e;
endpackage

// File: rtl/pgw_gap_timer.sv
// Counts ticks since the last accepted load; reports the accept window and expiry.
module pgw_gap_timer #(
  parameter int BLC_CYC = 25000,
  parameter int TMO_CYC = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  input  logic restart,
  output logic window_open,
  output logic expire
);
  localparam int CW = $clog2(TMO_CYC + 1);

  logic [CW-1:0] gap_q;

  function automatic logic at_limit(input logic [CW-1:0] v);
    return v == CW'(TMO_CYC - 1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)              gap_q <= '0;
    else if (restart)        gap_q <= '0;
    else if (run && tick)    gap_q <= gap_q + 1'b1;
  end

  assign window_open = gap_q < CW'(BLC_CYC);
  assign expire      = run && tick && !restart && at_limit(gap_q);
endmodule

// File: rtl/pgw_prog_timer.sv
// Fixed-length programming cycle counter.
module pgw_prog_timer #(
  parameter int PROG_CYC = 1250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  input  logic start,
  output logic done
);
  localparam int PW = $clog2(PROG_CYC + 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt_q <= '0;
    else if (start)       cnt_q <= '0;
    else if (run && tick) cnt_q <= cnt_q + 1'b1;
  end

  assign done = run && tick && (cnt_q == PW'(PROG_CYC - 1));
endmodule

// File: rtl/pgw_page_buffer.sv
// Slot storage, loaded flags, page register and last-byte register.
module pgw_page_buffer #(
  parameter int ADDR_W     = 18,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 128
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic                         clear,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] page_q,
  output logic [DATA_W-1:0]            last_q,
  output logic [PAGE_BYTES-1:0]        mask_q,
  output logic [PAGE_BYTES*DATA_W-1:0] flat_data
);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFF_W;

  function automatic logic [OFF_W-1:0] offset_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W-1:0];
  endfunction

  function automatic logic [PAGE_W-1:0] page_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFF_W];
  endfunction

  logic [OFF_W-1:0] wr_off;
  assign wr_off = offset_of(wr_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q <= '0;
      last_q <= '0;
    end else if (wr_en) begin
      page_q <= page_of(wr_addr);
      last_q <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) mask_q <= '0;
    else if (wr_en)      mask_q[wr_off] <= 1'b1;
  end

  for (genvar b = 0; b < PAGE_BYTES; b++) begin : g_slot
    logic [DATA_W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                               slot_q <= '0;
      else if (wr_en && wr_off == OFF_W'(b))    slot_q <= wr_data;
    end
    assign flat_data[b*DATA_W +: DATA_W] = mask_q[b] ? slot_q : {DATA_W{1'b1}};
  end
endmodule

// File: rtl/pgw_poll_status.sv
// Read path: polling/toggle status while busy, last byte while idle.
module pgw_poll_status #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              busy,
  input  logic [DATA_W-1:0] last_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              tog_q
);
  function automatic logic [DATA_W-1:0] poll_word(input logic msb, input logic tg);
    logic [DATA_W-1:0] w;
    w = '0;
    w[DATA_W-1] = ~msb;
    w[DATA_W-2] = tg;
    return w;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
      tog_q   <= 1'b0;
    end else if (rd_en) begin
      if (busy) begin
        tog_q   <= ~tog_q;
        rd_data <= poll_word(last_data[DATA_W-1], ~tog_q);
      end else begin
        rd_data <= last_data;
      end
    end
  end
endmodule

// File: rtl/page_load_ctrl.sv
module page_load_ctrl
  import pgw_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 128,
  parameter int BLC_CYC    = 25000,
  parameter int TMO_CYC    = 50000,
  parameter int PROG_CYC   = 1250000
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 tmr_tick,
  input  logic                                 ld_en,
  input  logic [ADDR_W-1:0]                    ld_addr,
  input  logic [DATA_W-1:0]                    ld_data,
  input  logic                                 ld_permit,
  input  logic                                 rd_en,
  output logic [DATA_W-1:0]                    rd_data,
  output logic                                 busy,
  output logic                                 commit_valid,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] commit_page,
  output logic [PAGE_BYTES*DATA_W-1:0]         commit_data,
  output logic [PAGE_BYTES-1:0]                commit_mask
);
  pgw_state_e state_q, state_d;

  // Named internal events
  logic in_load, in_prog, window_open, load_accept, load_expire, prog_done;
  logic [PAGE_BYTES-1:0] buf_mask;
  logic [DATA_W-1:0]     last_q;
  logic                  last_msb;
  logic                  tog_q;

  assign in_load     = (state_q == ST_LOAD);
  assign in_prog     = (state_q == ST_PROG);
  assign load_accept = ld_en && ld_permit &&
                       ((state_q == ST_IDLE) || (in_load && window_open));
  assign last_msb    = last_q[DATA_W-1];

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (load_accept) state_d = ST_LOAD;
      ST_LOAD: if (load_expire) state_d = ST_PROG;
      ST_PROG: if (prog_done)   state_d = ST_IDLE;
      default:                  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  pgw_gap_timer #(.BLC_CYC(BLC_CYC), .TMO_CYC(TMO_CYC)) u_gap (
    .clk(clk), .rst_n(rst_n), .tick(tmr_tick), .run(in_load),
    .restart(load_accept), .window_open(window_open), .expire(load_expire)
  );

  pgw_prog_timer #(.PROG_CYC(PROG_CYC)) u_prog (
    .clk(clk), .rst_n(rst_n), .tick(tmr_tick), .run(in_prog),
    .start(load_expire), .done(prog_done)
  );

  pgw_page_buffer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(load_accept), .wr_addr(ld_addr),
    .wr_data(ld_data), .clear(prog_done), .page_q(commit_page),
    .last_q(last_q), .mask_q(buf_mask), .flat_data(commit_data)
  );

  pgw_poll_status #(.DATA_W(DATA_W)) u_poll (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .busy(in_prog),
    .last_data(last_q), .rd_data(rd_data), .tog_q(tog_q)
  );

  assign busy         = in_prog;
  assign commit_valid = prog_done;
  assign commit_mask  = buf_mask;
endmodule

// File: rtl/pgw_checker.sv
module pgw_checker #(
  parameter int PAGE_BYTES = 128,
  parameter int DATA_W     = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  ld_en,
  input logic                  ld_permit,
  input logic                  rd_en,
  input logic [DATA_W-1:0]     rd_data,
  input logic                  busy,
  input logic                  commit_valid,
  input logic                  in_load,
  input logic                  window_open,
  input logic [PAGE_BYTES-1:0] buf_mask,
  input logic                  last_msb,
  input logic                  tog_q
);
  p_commit_while_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> busy);

  p_busy_ends_on_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(commit_valid));

  p_busy_load_dropped_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ld_en && !commit_valid) |=> $stable(buf_mask));

  p_late_load_dropped_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_load && !window_open && ld_en) |=> $stable(buf_mask));

  p_no_permit_dropped_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !ld_permit && !commit_valid) |=> $stable(buf_mask));

  p_flags_cleared_r11: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |=> (buf_mask == '0));

  p_poll_msb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_en) |=> (rd_data[DATA_W-1] == !last_msb));

  p_toggle_flip_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_en) |=> (tog_q != $past(tog_q)));
endmodule

bind page_load_ctrl pgw_checker #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_permit(ld_permit),
  .rd_en(rd_en), .rd_data(rd_data), .busy(busy), .commit_valid(commit_valid),
  .in_load(in_load), .window_open(window_open), .buf_mask(buf_mask),
  .last_msb(last_msb), .tog_q(tog_q)
);

// File: tb/page_load_ctrl_test.sv
`timescale 1ns/1ps
module page_load_ctrl_test;
  localparam int AW = 10, DW = 8, PB = 128, PGW = 3;
  localparam int BLC = 4, TMO = 8, PRG = 20;

  logic clk = 1'b0, rst_n = 1'b0, tmr_tick = 1'b1;
  logic ld_en = 1'b0, ld_permit = 1'b1, rd_en = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [DW-1:0] ld_data = '0;
  logic [DW-1:0] rd_data;
  logic busy, commit_valid;
  logic [PGW-1:0] commit_page;
  logic [PB*DW-1:0] commit_data;
  logic [PB-1:0] commit_mask;

  always #2 clk = ~clk;

  page_load_ctrl #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BYTES(PB),
                   .BLC_CYC(BLC), .TMO_CYC(TMO), .PROG_CYC(PRG)) uut (
    .clk(clk), .rst_n(rst_n), .tmr_tick(tmr_tick), .ld_en(ld_en),
    .ld_addr(ld_addr), .ld_data(ld_data), .ld_permit(ld_permit),
    .rd_en(rd_en), .rd_data(rd_data), .busy(busy),
    .commit_valid(commit_valid), .commit_page(commit_page),
    .commit_data(commit_data), .commit_mask(commit_mask));

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // Bench-side model of the page
  logic [DW-1:0] m_mem [PB];
  logic [PB-1:0] m_mask;
  logic [PGW-1:0] m_page;

  // Stimulus table: {address, data}
  localparam logic [AW+DW-1:0] VEC [6] = '{
    {10'h100, 8'h11}, {10'h105, 8'hA5}, {10'h17F, 8'h3C},
    {10'h105, 8'h5A}, {10'h1C0, 8'h80}, {10'h181, 8'h7E}};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_clear();
    for (int b = 0; b < PB; b++) m_mem[b] = 8'h00;
    m_mask = '0;
  endtask

  task automatic model_put(input logic [AW-1:0] a, input logic [DW-1:0] d);
    m_mem[a[6:0]] = d;
    m_mask[a[6:0]] = 1'b1;
    m_page = a[AW-1:7];
  endtask

  task automatic load(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic p);
    ld_en = 1'b1; ld_addr = a; ld_data = d; ld_permit = p;
    @(negedge clk);
    ld_en = 1'b0; ld_permit = 1'b1;
  endtask

  task automatic rd(output logic [DW-1:0] v);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic wait_commit(input string req);
    int k;
    k = 0;
    while (!commit_valid && k < 200) begin
      @(negedge clk);
      k++;
    end
    chk(commit_valid, req, 32'(commit_valid), 32'd1);
  endtask

  task automatic check_commit(input string req);
    int bad;
    logic [DW-1:0] e;
    bad = 0;
    chk(commit_page == m_page, {req, " page"}, 32'(commit_page), 32'(m_page));
    chk(commit_mask == m_mask, {req, " mask"}, commit_mask[31:0], m_mask[31:0]);
    for (int b = 0; b < PB; b++) begin
      e = m_mask[b] ? m_mem[b] : 8'hFF;
      if (commit_data[b*DW +: DW] !== e) begin
        if (bad == 0)
          chk(1'b0, {req, " data"}, 32'(commit_data[b*DW +: DW]), 32'(e));
        bad++;
      end
    end
    if (bad == 0) chk(1'b1, req, 0, 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] r0, r1;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    chk(busy == 1'b0, "reset busy", 32'(busy), 0);
    chk(commit_valid == 1'b0, "reset commit", 32'(commit_valid), 0);
    chk(commit_mask == '0, "reset mask", commit_mask[31:0], 0);
    chk(rd_data == '0, "reset rd_data", 32'(rd_data), 0);

    // Table walk: R1 R5 R6 R7, then polling R9 R10
    model_clear();
    for (int i = 0; i < 6; i++) begin
      load(VEC[i][AW+DW-1:DW], VEC[i][DW-1:0], 1'b1);
      model_put(VEC[i][AW+DW-1:DW], VEC[i][DW-1:0]);
      idle(1);
    end
    while (!busy) @(negedge clk);
    rd(r0);
    rd(r1);
    chk(r0[7] == 1'b1, "R9 poll bit7", 32'(r0), 32'h80);
    chk(r1[7] == 1'b1, "R9 poll bit7 again", 32'(r1), 32'h80);
    chk(r0[6] != r1[6], "R10 toggle bit6", 32'(r1[6]), 32'(!r0[6]));
    wait_commit("R8 commit seen");
    check_commit("R1 R5 R6 R7 table page");
    idle(1);
    chk(busy == 1'b0, "R8 busy falls", 32'(busy), 0);
    rd(r0);
    rd(r1);
    chk(r0 == 8'h7E, "R10 idle read", 32'(r0), 32'h7E);
    chk(r1 == 8'h7E, "R10 idle read steady", 32'(r1), 32'h7E);

    // Exact timing, latest in-window load R2 R4 R8 R11
    model_clear();
    load(10'h002, 8'h42, 1'b1); model_put(10'h002, 8'h42);
    idle(BLC - 1);
    load(10'h003, 8'h43, 1'b1); model_put(10'h003, 8'h43);
    idle(TMO - 1);
    chk(busy == 1'b0, "R2 R4 busy before timeout", 32'(busy), 0);
    idle(1);
    chk(busy == 1'b1, "R4 busy at timeout", 32'(busy), 1);
    idle(PRG - 2);
    chk(commit_valid == 1'b0, "R8 commit early", 32'(commit_valid), 0);
    idle(1);
    chk(commit_valid == 1'b1, "R8 commit on time", 32'(commit_valid), 1);
    check_commit("R11 R2 fresh page");
    idle(1);
    chk(commit_valid == 1'b0, "R8 commit one cycle", 32'(commit_valid), 0);
    chk(busy == 1'b0, "R8 busy after commit", 32'(busy), 0);

    // Late load discarded, timer not restarted R3
    model_clear();
    load(10'h080, 8'h01, 1'b1); model_put(10'h080, 8'h01);
    idle(BLC);
    load(10'h087, 8'h77, 1'b1);
    idle(2);
    chk(busy == 1'b0, "R3 busy before timeout", 32'(busy), 0);
    idle(1);
    chk(busy == 1'b1, "R3 timer not restarted", 32'(busy), 1);
    wait_commit("R3 commit seen");
    check_commit("R3 late load dropped");
    idle(1);

    // Loads during busy discarded R8
    model_clear();
    load(10'h084, 8'h44, 1'b1); model_put(10'h084, 8'h44);
    while (!busy) @(negedge clk);
    load(10'h086, 8'h66, 1'b1);
    wait_commit("R8 commit seen 2");
    check_commit("R8 busy load dropped");
    idle(1);
    rd(r0);
    chk(r0 == 8'h44, "R8 last byte unchanged", 32'(r0), 32'h44);

    // Permission low R12
    model_clear();
    load(10'h101, 8'h99, 1'b0);
    idle(TMO + 4);
    chk(busy == 1'b0, "R12 no load started", 32'(busy), 0);
    load(10'h108, 8'h88, 1'b1); model_put(10'h108, 8'h88);
    wait_commit("R12 commit seen");
    check_commit("R12 unpermitted slot empty");
    idle(1);

    // Tick gating R13
    model_clear();
    tmr_tick = 1'b0;
    load(10'h00A, 8'hAA, 1'b1); model_put(10'h00A, 8'hAA);
    idle(30);
    chk(busy == 1'b0, "R13 held without tick", 32'(busy), 0);
    tmr_tick = 1'b1;
    idle(TMO - 1);
    chk(busy == 1'b0, "R13 before timeout", 32'(busy), 0);
    idle(1);
    chk(busy == 1'b1, "R13 timeout after ticks", 32'(busy), 1);
    wait_commit("R13 commit seen");
    check_commit("R13 page");
    idle(2);

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule